// File: doc/BRIEF.md
# Parallel EEPROM page-write controller

This block is the host side of an asynchronous, byte-wide nonvolatile memory on a parallel bus: a 15-bit address, an 8-bit data path split into separate in and out halves with a drive enable, and three active-low strobes for chip select, output enable and write enable. A client hands it commands over a valid/ready interface. Each command is either a single-byte read or a write burst of 1 to 128 bytes. The bytes of a burst then arrive one at a time over a second valid/ready channel.

After the final byte of a burst has been loaded, the memory programs itself without help. The controller does not wait a fixed worst-case time. It reads the last address again and again, and the write is complete once two reads in a row give the same value of data bit 6. If that does not happen within a time limit, the attempt is abandoned with an error. Bursts that would pass the end of a 128-byte page are refused before any bus activity. The block also holds off reads and writes for their separate power-up intervals.

All times are parameters in microseconds and are converted to clock cycles using the clock-frequency parameter. The strobe pulse width and the gap between status reads are parameters given directly in cycles.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: While reset is held and right after it, all three strobes are high (inactive), the data drive enable is low and `cmd_ready` is low.
- R2: A read command is accepted only after the power-up read interval has passed since reset release, and a write command only after the longer power-up write interval. Before that, `cmd_ready` stays low for that command kind.
- R3: A read asserts chip select and output enable (both low) with write enable high and the data drive off for `STROBE_CYC` cycles. It then returns the captured byte on `rd_data` with a one-cycle `rd_valid`, visible `STROBE_CYC`+1 clock edges after the edge that accepted the command.
- R4: While write enable is low, chip select is low, output enable is high and the controller drives the byte on `mem_dq_out`. The data drive enable is high only during write-enable-low cycles.
- R5: In every read there is at least one clock with output enable high and the data drive off both before output enable falls and after it rises.
- R6: A write command with length 0, length above 128, or low address bits [6:0] plus length above 128 is refused. `err_page` pulses in the cycle right after acceptance, and no strobe goes low for it.
- R7: An accepted burst stores its bytes at consecutive addresses from the start address, one byte per `wdata` handshake. Address bits [14:7] do not change during the burst.
- R8: After the last byte, the controller reads the last address repeatedly with a gap of `POLL_GAP_CYC` cycles. It pulses `done` on the first pair of consecutive reads whose bit 6 agree, and not before.
- R9: If polling has not finished within the timeout interval, the controller pulses `err_timeout`, releases the bus (chip select high, drive off) and accepts new commands again.
- R10: Output enable and write enable are never low at the same time.
- R11: Whenever chip select is high, output enable and write enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| cmd_write | input | 1 | 1 = write burst, 0 = single-byte read |
| cmd_addr | input | 15 | Start address (read or burst) |
| cmd_len | input | 8 | Burst length in bytes, 1 to 128 valid |
| wdata_valid | input | 1 | Burst byte offered |
| wdata_ready | output | 1 | Burst byte taken this cycle when high with `wdata_valid` |
| wdata | input | 8 | Burst byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` holds the read byte |
| rd_data | output | 8 | Byte returned by a read command |
| done | output | 1 | One-cycle pulse, burst write finished |
| err_page | output | 1 | One-cycle pulse, write command refused |
| err_timeout | output | 1 | One-cycle pulse, completion polling timed out |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Only two results have a fixed latency. A refused write shows `err_page` one edge after acceptance, and read data shows `rd_valid` `STROBE_CYC`+1 edges after acceptance. The driver stamps each expected item with that exact due cycle and the monitor compares against a free-running edge count, sampling on the falling clock edge. `done` and `err_timeout` depend on how long the bench's memory model keeps its status bit toggling, so they are matched in order only. Each `done` is additionally checked against the recorded sequence of status bits: the last two must agree and no earlier neighbours may. Strobe relations are watched on every cycle by the model and tallied into per-requirement checks.

// File: rtl/eepc_pkg.sv
package eepc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WR_WAIT,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD,
      ST_POLL_GAP,
      ST_RD_PRE,
      ST_RD_PULSE,
      ST_RD_POST
   } seq_state_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } bus_ctl_t;

   localparam bus_ctl_t BUS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

   // Round up so a converted delay is never shorter than asked for.
   function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                    longint unsigned us);
      return (clk_hz * us + 64'd999_999) / 64'd1_000_000;
   endfunction

   // Strobe levels that belong to each sequencer state.
   function automatic bus_ctl_t ctl_for(seq_state_t s);
      bus_ctl_t c;
      c = BUS_IDLE;
      case (s)
         ST_WR_SETUP, ST_WR_HOLD, ST_RD_PRE, ST_RD_POST: c.ce_n = 1'b0;
         ST_WR_PULSE: begin
            c.ce_n  = 1'b0;
            c.we_n  = 1'b0;
            c.dq_oe = 1'b1;
         end
         ST_RD_PULSE: begin
            c.ce_n = 1'b0;
            c.oe_n = 1'b0;
         end
         default: c = BUS_IDLE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/eepc_delay_gate.sv
module eepc_delay_gate #(
   parameter longint unsigned LIMIT = 100,
   localparam int unsigned    CNT_W = $clog2(LIMIT + 2)
) (
   input  logic clk,
   input  logic rst_n,
   output logic reached
);

   logic [CNT_W-1:0] cnt_q;

   assign reached = (cnt_q >= CNT_W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!reached)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // Once open, the gate stays open until the next reset.
   p_gate_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reached |=> reached);

endmodule

// File: rtl/eepc_powerup.sv
module eepc_powerup #(
   parameter longint unsigned RD_CYC = 100,
   parameter longint unsigned WR_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   output logic rd_ok,
   output logic wr_ok
);

   logic [1:0] ok_vec;

   for (genvar g = 0; g < 2; g++) begin : g_gate
      localparam longint unsigned LIM = (g == 0) ? RD_CYC : WR_CYC;
      eepc_delay_gate #(.LIMIT(LIM)) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .reached (ok_vec[g])
      );
   end

   assign rd_ok = ok_vec[0];
   assign wr_ok = ok_vec[1];

   if (WR_CYC >= RD_CYC) begin : g_order_chk
      p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_ok |-> rd_ok);
   end

endmodule

// File: rtl/eepc_page_check.sv
module eepc_page_check #(
   parameter int unsigned  PAGE_BYTES = 128,
   localparam int unsigned OFF_W      = $clog2(PAGE_BYTES),
   localparam int unsigned LEN_W      = OFF_W + 1
) (
   input  logic [OFF_W-1:0] start_ofs,
   input  logic [LEN_W-1:0] len,
   output logic             fits
);

   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end

   logic [LEN_W:0] end_ofs;

   assign end_ofs = (LEN_W+1)'(start_ofs) + (LEN_W+1)'(len);
   assign fits    = (len != '0)
                 && (len <= LEN_W'(PAGE_BYTES))
                 && (end_ofs <= (LEN_W+1)'(PAGE_BYTES));

   always_comb begin
      if (fits)
         p_fit_bound_r6: assert (end_ofs > (LEN_W+1)'(start_ofs));
   end

endmodule

// File: rtl/eepc_seq.sv
module eepc_seq
   import eepc_pkg::*;
#(
   parameter int unsigned     ADDR_W       = 15,
   parameter int unsigned     DATA_W       = 8,
   parameter int unsigned     PAGE_BYTES   = 128,
   parameter int unsigned     STROBE_CYC   = 13,
   parameter int unsigned     POLL_GAP_CYC = 4,
   parameter longint unsigned TMO_CYC      = 1_250_000,
   parameter int unsigned     STATUS_BIT   = 6,
   localparam int unsigned    OFF_W        = $clog2(PAGE_BYTES),
   localparam int unsigned    LEN_W        = OFF_W + 1,
   localparam int unsigned    MAX_CNT      = (STROBE_CYC > POLL_GAP_CYC) ? STROBE_CYC : POLL_GAP_CYC,
   localparam int unsigned    CNT_W        = $clog2(MAX_CNT + 1),
   localparam int unsigned    TMO_W        = $clog2(TMO_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ok,
   input  logic              wr_ok,
   input  logic              page_ok,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              wdata_valid,
   output logic              wdata_ready,
   input  logic [DATA_W-1:0] wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err_page,
   output logic              err_timeout,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(POLL_GAP_CYC - 1);
   localparam logic [TMO_W-1:0] TMO_LAST    = TMO_W'(TMO_CYC - 1);

   seq_state_t        state_q, state_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [LEN_W-1:0]  rem_q, rem_d;
   logic [DATA_W-1:0] byte_q, byte_d;
   logic [DATA_W-1:0] rdat_q, rdat_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [TMO_W-1:0]  tmo_q, tmo_d;
   logic              poll_q, poll_d;
   logic              prev_q, prev_d;
   logic              have_q, have_d;
   logic              rdv_q, rdv_d;
   logic              done_q, done_d;
   logic              epg_q, epg_d;
   logic              etm_q, etm_d;
   bus_ctl_t          ctl_q;
   logic              in_poll;

   assign cmd_ready   = (state_q == ST_IDLE) && (cmd_write ? wr_ok : rd_ok);
   assign wdata_ready = (state_q == ST_WR_WAIT);
   assign in_poll     = poll_q && (state_q inside {ST_POLL_GAP, ST_RD_PRE, ST_RD_PULSE, ST_RD_POST});

   always_comb begin
      state_d = state_q;
      addr_d  = addr_q;
      rem_d   = rem_q;
      byte_d  = byte_q;
      rdat_d  = rdat_q;
      cnt_d   = cnt_q;
      tmo_d   = tmo_q;
      poll_d  = poll_q;
      prev_d  = prev_q;
      have_d  = have_q;
      rdv_d   = 1'b0;
      done_d  = 1'b0;
      epg_d   = 1'b0;
      etm_d   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (cmd_valid && cmd_ready) begin
               addr_d = cmd_addr;
               poll_d = 1'b0;
               if (!cmd_write) begin
                  state_d = ST_RD_PRE;
               end else if (page_ok) begin
                  rem_d   = cmd_len;
                  state_d = ST_WR_WAIT;
               end else begin
                  epg_d = 1'b1;
               end
            end
         end
         ST_WR_WAIT: begin
            if (wdata_valid) begin
               byte_d  = wdata;
               state_d = ST_WR_SETUP;
            end
         end
         ST_WR_SETUP: begin
            cnt_d   = '0;
            state_d = ST_WR_PULSE;
         end
         ST_WR_PULSE: begin
            if (cnt_q == STROBE_LAST) state_d = ST_WR_HOLD;
            else                      cnt_d   = cnt_q + CNT_W'(1);
         end
         ST_WR_HOLD: begin
            if (rem_q == LEN_W'(1)) begin
               poll_d  = 1'b1;
               have_d  = 1'b0;
               tmo_d   = '0;
               cnt_d   = '0;
               state_d = ST_POLL_GAP;
            end else begin
               rem_d   = rem_q - LEN_W'(1);
               addr_d  = addr_q + ADDR_W'(1);
               state_d = ST_WR_WAIT;
            end
         end
         ST_POLL_GAP: begin
            if (cnt_q == GAP_LAST) state_d = ST_RD_PRE;
            else                   cnt_d   = cnt_q + CNT_W'(1);
         end
         ST_RD_PRE: begin
            cnt_d   = '0;
            state_d = ST_RD_PULSE;
         end
         ST_RD_PULSE: begin
            if (cnt_q == STROBE_LAST) begin
               rdat_d  = mem_dq_in;
               rdv_d   = !poll_q;
               state_d = ST_RD_POST;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_RD_POST: begin
            if (!poll_q) begin
               state_d = ST_IDLE;
            end else if (have_q && (prev_q == rdat_q[STATUS_BIT])) begin
               done_d  = 1'b1;
               poll_d  = 1'b0;
               state_d = ST_IDLE;
            end else begin
               prev_d  = rdat_q[STATUS_BIT];
               have_d  = 1'b1;
               cnt_d   = '0;
               state_d = ST_POLL_GAP;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      // Polling window: give up and release the bus once it expires.
      if (in_poll) begin
         if (tmo_q == TMO_LAST) begin
            etm_d   = 1'b1;
            done_d  = 1'b0;
            poll_d  = 1'b0;
            state_d = ST_IDLE;
         end else begin
            tmo_d = tmo_q + TMO_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         byte_q  <= '0;
         rdat_q  <= '0;
         cnt_q   <= '0;
         tmo_q   <= '0;
         poll_q  <= 1'b0;
         prev_q  <= 1'b0;
         have_q  <= 1'b0;
         rdv_q   <= 1'b0;
         done_q  <= 1'b0;
         epg_q   <= 1'b0;
         etm_q   <= 1'b0;
         ctl_q   <= BUS_IDLE;
      end else begin
         state_q <= state_d;
         addr_q  <= addr_d;
         rem_q   <= rem_d;
         byte_q  <= byte_d;
         rdat_q  <= rdat_d;
         cnt_q   <= cnt_d;
         tmo_q   <= tmo_d;
         poll_q  <= poll_d;
         prev_q  <= prev_d;
         have_q  <= have_d;
         rdv_q   <= rdv_d;
         done_q  <= done_d;
         epg_q   <= epg_d;
         etm_q   <= etm_d;
         ctl_q   <= ctl_for(state_d);
      end
   end

   assign rd_valid    = rdv_q;
   assign rd_data     = rdat_q;
   assign done        = done_q;
   assign err_page    = epg_q;
   assign err_timeout = etm_q;
   assign mem_addr    = addr_q;
   assign mem_ce_n    = ctl_q.ce_n;
   assign mem_oe_n    = ctl_q.oe_n;
   assign mem_we_n    = ctl_q.we_n;
   assign mem_dq_oe   = ctl_q.dq_oe;
   assign mem_dq_out  = byte_q;

   p_read_data_from_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(!mem_oe_n) && mem_dq_oe == 1'b0));

   p_write_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   p_drive_only_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);

   p_gap_before_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe));

   p_gap_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (!mem_dq_oe && mem_we_n));

   p_refused_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_write && !page_ok) |=> (err_page && mem_ce_n));

   p_page_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
         |-> $stable(addr_q[ADDR_W-1:OFF_W]));

   p_done_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(state_q) == ST_RD_POST && mem_oe_n));

   p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> (mem_ce_n && !mem_dq_oe && state_q == ST_IDLE));

   p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   p_inhibit_when_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_oe_n && mem_we_n));

   p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, done, err_page, err_timeout}));

endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
   import eepc_pkg::*;
#(
   parameter longint unsigned CLK_HZ       = 125_000_000,
   parameter longint unsigned PU_READ_US   = 100,
   parameter longint unsigned PU_WRITE_US  = 5000,
   parameter longint unsigned TIMEOUT_US   = 10_000,
   parameter int unsigned     STROBE_CYC   = 13,
   parameter int unsigned     POLL_GAP_CYC = 4,
   parameter int unsigned     ADDR_W       = 15,
   parameter int unsigned     DATA_W       = 8,
   parameter int unsigned     PAGE_BYTES   = 128,
   parameter int unsigned     STATUS_BIT   = 6,
   localparam int unsigned    OFF_W        = $clog2(PAGE_BYTES),
   localparam int unsigned    LEN_W        = OFF_W + 1,
   localparam longint unsigned PU_RD_CYC   = us_to_cycles(CLK_HZ, PU_READ_US),
   localparam longint unsigned PU_WR_CYC   = us_to_cycles(CLK_HZ, PU_WRITE_US),
   localparam longint unsigned TMO_CYC     = us_to_cycles(CLK_HZ, TIMEOUT_US)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              wdata_valid,
   output logic              wdata_ready,
   input  logic [DATA_W-1:0] wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err_page,
   output logic              err_timeout,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   if (STROBE_CYC < 1 || POLL_GAP_CYC < 1) begin : g_bad_cyc
      $error("STROBE_CYC and POLL_GAP_CYC must be at least 1");
   end
   if (STATUS_BIT >= DATA_W) begin : g_bad_bit
      $error("STATUS_BIT must lie inside the data width");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_addr
      $error("page must be smaller than the address space");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("timeout must cover at least two cycles");
   end

   logic rd_ok, wr_ok, page_ok;

   eepc_powerup #(
      .RD_CYC (PU_RD_CYC),
      .WR_CYC (PU_WR_CYC)
   ) u_powerup (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok)
   );

   eepc_page_check #(
      .PAGE_BYTES (PAGE_BYTES)
   ) u_page_check (
      .start_ofs (cmd_addr[OFF_W-1:0]),
      .len       (cmd_len),
      .fits      (page_ok)
   );

   eepc_seq #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .PAGE_BYTES   (PAGE_BYTES),
      .STROBE_CYC   (STROBE_CYC),
      .POLL_GAP_CYC (POLL_GAP_CYC),
      .TMO_CYC      (TMO_CYC),
      .STATUS_BIT   (STATUS_BIT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_ok       (rd_ok),
      .wr_ok       (wr_ok),
      .page_ok     (page_ok),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_write   (cmd_write),
      .cmd_addr    (cmd_addr),
      .cmd_len     (cmd_len),
      .wdata_valid (wdata_valid),
      .wdata_ready (wdata_ready),
      .wdata       (wdata),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .done        (done),
      .err_page    (err_page),
      .err_timeout (err_timeout),
      .mem_addr    (mem_addr),
      .mem_ce_n    (mem_ce_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_dq_out  (mem_dq_out),
      .mem_dq_oe   (mem_dq_oe),
      .mem_dq_in   (mem_dq_in)
   );

endmodule

// File: tb/test_eeprom_page_ctrl.sv
module test_eeprom_page_ctrl;

   localparam int STROBE = 2;
   localparam int GAP    = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
   logic [14:0] cmd_addr = '0;
   logic [7:0]  cmd_len = '0;
   logic        wdata_valid = 1'b0, wdata_ready;
   logic [7:0]  wdata = '0;
   logic        rd_valid, done, err_page, err_timeout;
   logic [7:0]  rd_data;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  dq_in = '0;

   eeprom_page_ctrl #(
      .CLK_HZ       (1_000_000),
      .STROBE_CYC   (STROBE),
      .POLL_GAP_CYC (GAP)
   ) i_eeprom_page_ctrl (
      .clk (clk), .rst_n (rst_n),
      .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_write (cmd_write),
      .cmd_addr (cmd_addr), .cmd_len (cmd_len),
      .wdata_valid (wdata_valid), .wdata_ready (wdata_ready), .wdata (wdata),
      .rd_valid (rd_valid), .rd_data (rd_data), .done (done),
      .err_page (err_page), .err_timeout (err_timeout),
      .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
      .mem_we_n (mem_we_n), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
      .mem_dq_in (dq_in)
   );

   int total = 0, bad = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] mem [int];
   bit   tog = 1'b0;
   int   busy = 0, busy_n = 3;
   bit   we_low = 1'b0;
   int   lat_addr = 0;
   logic [7:0] lat_data = '0;
   logic oe_prev = 1'b1, dq_oe_prev = 1'b0;
   bit   hist [$];
   int   ce_low_cnt = 0;
   int   bad4 = 0, bad5 = 0, bad10 = 0, bad11 = 0;

   always @(negedge clk) begin
      if (!mem_ce_n && !mem_we_n) begin
         lat_addr = int'(mem_addr);
         lat_data = mem_dq_out;
         we_low   = 1'b1;
      end else if (we_low && mem_we_n) begin
         mem[lat_addr] = lat_data;
         busy   = busy_n;
         we_low = 1'b0;
      end
      if (!mem_ce_n && !mem_oe_n && oe_prev) begin
         if (busy > 0) begin
            tog   = !tog;
            busy--;
            dq_in = {1'b0, tog, 6'b0};
         end else begin
            dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
         end
         hist.push_back(dq_in[6]);
      end
      if (!mem_ce_n) ce_low_cnt++;
      if (!mem_we_n && (mem_ce_n || !mem_oe_n || !mem_dq_oe)) bad4++;
      if (mem_dq_oe && mem_we_n) bad4++;
      if (!mem_oe_n && oe_prev && dq_oe_prev) bad5++;
      if (mem_oe_n && !oe_prev && mem_dq_oe) bad5++;
      if (!mem_oe_n && !mem_we_n) bad10++;
      if (mem_ce_n && (!mem_oe_n || !mem_we_n)) bad11++;
      oe_prev    = mem_oe_n;
      dq_oe_prev = mem_dq_oe;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      int         kind;   // 0 read, 1 done, 2 page error, 3 timeout
      int         due;    // -1: any cycle
      logic [7:0] data;
      string      req;
   } exp_t;
   exp_t q [$];

   always @(negedge clk) begin
      if (rst_n && (rd_valid || done || err_page || err_timeout)) begin
         int got;
         got = rd_valid ? 0 : done ? 1 : err_page ? 2 : 3;
         if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected result", got, -1);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(got == e.kind, e.req, "result kind", got, e.kind);
            if (e.due >= 0) check(cyc == e.due, e.req, "result cycle", cyc, e.due);
            if (got == 0 && e.kind == 0)
               check(rd_data == e.data, e.req, "read data", int'(rd_data), int'(e.data));
            if (got == 1) begin
               bit ok;
               int n;
               n  = hist.size();
               ok = (n >= 2) && (hist[n-1] == hist[n-2]);
               for (int i = 0; i + 2 < n; i++) if (hist[i] == hist[i+1]) ok = 1'b0;
               check(ok, "R8", "poll sequence ends on first equal pair", n, 2);
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic send_cmd(bit wr, int addr, int len, int kind, int due_off,
                           logic [7:0] data, string req);
      exp_t e;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = 15'(addr); cmd_len = 8'(len);
      #1;
      while (!cmd_ready) begin @(negedge clk); #1; end
      e.kind = kind; e.due = (due_off < 0) ? -1 : cyc + 1 + due_off;
      e.data = data; e.req = req;
      q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(int addr, logic [7:0] exp, string req);
      send_cmd(1'b0, addr, 1, 0, STROBE + 1, exp, req);
      wait_idle();
   endtask

   logic [7:0] wbuf [128];

   task automatic do_write(int addr, int len, int kind, string req);
      hist.delete();
      send_cmd(1'b1, addr, len, kind, (kind == 2) ? 0 : -1, 8'h00, req);
      if (kind != 2) begin
         for (int i = 0; i < len; i++) begin
            wdata = wbuf[i]; wdata_valid = 1'b1;
            #1;
            while (!wdata_ready) begin @(negedge clk); #1; end
            @(negedge clk);
         end
         wdata_valid = 1'b0;
      end
      wait_idle();
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes idle in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);
      check(!mem_dq_oe, "R1", "drive off in reset", mem_dq_oe, 0);
      check(!cmd_ready, "R1", "cmd_ready low in reset", cmd_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && !mem_dq_oe && !cmd_ready, "R1", "idle after release",
            {mem_ce_n, mem_dq_oe, cmd_ready}, 4);

      // R2: power-up gating
      repeat (50) @(negedge clk);
      check(!cmd_ready, "R2", "read refused before read delay", cmd_ready, 0);
      repeat (80) @(negedge clk);
      check(cmd_ready, "R2", "read allowed after read delay", cmd_ready, 1);
      cmd_write = 1'b1; #1;
      check(!cmd_ready, "R2", "write refused before write delay", cmd_ready, 0);
      cmd_write = 1'b0;

      // R3: read of an erased location
      do_read(16'h1234, 8'hFF, "R3");

      repeat (5000) @(negedge clk);
      cmd_write = 1'b1; #1;
      check(cmd_ready, "R2", "write allowed after write delay", cmd_ready, 1);
      cmd_write = 1'b0;

      // R7/R8: short burst
      busy_n = 3;
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F; wbuf[3] = 8'hF0;
      do_write(16'h0100, 4, 1, "R8");
      do_read(16'h0100, 8'hA5, "R7");
      do_read(16'h0101, 8'h3C, "R7");
      do_read(16'h0102, 8'h0F, "R7");
      do_read(16'h0103, 8'hF0, "R7");

      // R7: full page
      for (int i = 0; i < 128; i++) wbuf[i] = 8'(i * 7 + 3);
      do_write(16'h4F80, 128, 1, "R7");
      do_read(16'h4F80, 8'(3), "R7");
      do_read(16'h4FC0, 8'(64 * 7 + 3), "R7");
      do_read(16'h4FFF, 8'(127 * 7 + 3), "R7");

      // R7: single byte at the last slot of a page
      wbuf[0] = 8'h42;
      do_write(16'h007F, 1, 1, "R7");
      do_read(16'h007F, 8'h42, "R7");

      // R6: refused bursts, no bus activity
      begin
         int snap;
         snap = ce_low_cnt;
         do_write(16'h007F, 2, 2, "R6");
         do_write(16'h0000, 0, 2, "R6");
         do_write(16'h0000, 129, 2, "R6");
         do_write(16'h0050, 64, 2, "R6");
         check(ce_low_cnt == snap, "R6", "no chip select on refusal", ce_low_cnt, snap);
      end
      do_read(16'h0080, 8'hFF, "R6");

      // R8: memory ready at once, two equal reads suffice
      busy_n = 0;
      wbuf[0] = 8'h77;
      do_write(16'h0200, 1, 1, "R8");
      check(hist.size() == 2, "R8", "two polls when already finished", hist.size(), 2);
      do_read(16'h0200, 8'h77, "R8");

      // R9: status bit never settles
      busy_n = 1_000_000;
      wbuf[0] = 8'h19;
      do_write(16'h0300, 1, 3, "R9");
      check(mem_ce_n && !mem_dq_oe, "R9", "bus released after timeout",
            {mem_ce_n, mem_dq_oe}, 2);
      cmd_write = 1'b1; #1;
      check(cmd_ready, "R9", "ready again after timeout", cmd_ready, 1);
      cmd_write = 1'b0;
      busy = 0; busy_n = 3;
      do_read(16'h0103, 8'hF0, "R9");

      // Whole-run strobe rules
      check(bad4 == 0, "R4", "write phase strobe/drive violations", bad4, 0);
      check(bad5 == 0, "R5", "read bus-release violations", bad5, 0);
      check(bad10 == 0, "R10", "oe and we both low", bad10, 0);
      check(bad11 == 0, "R11", "strobe low while deselected", bad11, 0);
      check(q.size() == 0, "R8", "outstanding results", q.size(), 0);
      finish_run();
   end

endmodule